// File: doc/BRIEF.md
# Indirect Post-Increment Move Unit

This block is the execution sequencer for the two indirect post-increment move instructions of an 8-bit accumulator CPU. When it receives a decoded opcode and a one-byte pointer address, it first fetches a pointer byte from data RAM. It then either loads the byte that the pointer addresses into the accumulator, or stores the accumulator at that address. Last, it writes the pointer back increased by one. The RAM is a synchronous single-port memory split into pages. The pointer byte always lives in the current page. The data access uses a separate read page for loads and a separate write page for stores, so software can move data between pages without changing the current page.

The block holds the accumulator and three page registers. Software loads them through a small register-write port while the block is idle. The state machine has five states:

- `ST_IDLE`: waits for a start.
- `ST_PTR_RD`: addresses the pointer in the current page.
- `ST_DATA`: uses the returned pointer as the data address, and writes for a store.
- `ST_WB`: writes back the incremented pointer and, for a load, captures the data.
- `ST_DONE`: raises done for one cycle.

The transitions are:

- idle to pointer-read, when start carries a legal opcode;
- pointer-read to data;
- data to write-back;
- write-back to done;
- done to idle.

A start with an illegal opcode leaves the machine in idle and pulses the illegal flag. A parameter can switch paging off. With paging off, every access goes to page 0.

Top module: `ipi_move_unit`

## Requirements
- R1: Opcode 0x3E (load) puts the byte at address P of the read page into the accumulator. P is the byte stored at the operand address of the current page.
- R2: Opcode 0x3F (store) writes the accumulator to address P of the write page. The read page is left untouched, and the accumulator is unchanged.
- R3: After the data access, the byte at the operand address of the current page becomes (P+1) mod 256. The write-back happens in the cycle that follows the data cycle. 0xFF wraps to 0x00.
- R4: The pointer is read from and written to the current page. The current, read and write page registers keep their values through an instruction.
- R5: A legal start accepted at clock edge E raises done for exactly one cycle, in the cycle after edge E+3. Busy is high from edge E until done falls.
- R6: A start while busy is ignored: no extra RAM access and no extra done.
- R7: Any opcode other than 0x3E or 0x3F raises illegal for one cycle after the start edge. It causes no RAM write and no done, and the accumulator stays unchanged.
- R8: The register-write port selects with code 0 the current page, 1 the read page, 2 the write page and 3 the accumulator. Writes are ignored while busy.
- R9: With paging disabled, the RAM page output is 0 for every access, and the page registers read 0.
- R10: After reset, the accumulator and page registers are 0, and busy, done, illegal and the RAM write enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | 8 | Decoded opcode byte |
| operand | input | 8 | Address of the pointer byte |
| reg_we | input | 1 | Register-write strobe |
| reg_sel | input | 2 | Register-write target code |
| reg_wdata | input | 8 | Register-write data |
| mem_addr | output | 8 | RAM address |
| mem_page | output | PAGE_W | RAM page |
| mem_wdata | output | 8 | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | 8 | RAM read data, one cycle after address |
| acc | output | 8 | Accumulator |
| cur_page | output | PAGE_W | Current page register |
| rd_page | output | PAGE_W | Read page register |
| wr_page | output | PAGE_W | Write page register |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-opcode pulse |

## Verification
The assertions assume a synchronous RAM that returns the addressed byte exactly one cycle later. The bench's RAM model behaves this way, and its preload path is used only while both units are idle. The assertions also assume that start and the register port change only between clock edges. The bench therefore drives every input on the falling edge. Vectors never place the pointer byte at the same page and address as the data byte, because that overlap would make the expected result depend on the access order.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PTR_RD = 3'd1,
        ST_DATA   = 3'd2,
        ST_WB     = 3'd3,
        ST_DONE   = 3'd4
    } ipi_state_e;

    typedef enum logic [1:0] {
        SEL_CUR  = 2'd0,
        SEL_RDPG = 2'd1,
        SEL_WRPG = 2'd2,
        SEL_ACC  = 2'd3
    } ipi_sel_e;
endpackage

// File: rtl/ipi_seq_fsm.sv
`timescale 1ns/1ps
module ipi_seq_fsm
    import ipi_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter logic [7:0]  OPC_LOAD  = 8'h3E,
    parameter logic [7:0]  OPC_STORE = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] operand,
    output ipi_state_e        state,
    output logic              is_store,
    output logic [DATA_W-1:0] ptr_addr,
    output logic              illegal
);
    ipi_state_e state_nx;
    logic       legal;
    logic       accept;

    assign legal  = (opcode == OPC_LOAD) || (opcode == OPC_STORE);
    assign accept = start && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept && legal) state_nx = ST_PTR_RD;
            ST_PTR_RD: state_nx = ST_DATA;
            ST_DATA:   state_nx = ST_WB;
            ST_WB:     state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_store <= 1'b0;
            ptr_addr <= '0;
            illegal  <= 1'b0;
        end else begin
            illegal <= accept && !legal;
            if (accept && legal) begin
                is_store <= (opcode == OPC_STORE);
                ptr_addr <= operand;
            end
        end
    end

    // R3: write-back only ever follows the data step
    assert_wb_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WB) |-> ($past(state) == ST_DATA));

    // R6: a running sequence never restarts on a new start
    assert_no_restart_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_PTR_RD));
endmodule

// File: rtl/ipi_ctx_regs.sv
`timescale 1ns/1ps
module ipi_ctx_regs
    import ipi_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 3,
    parameter bit PAGING_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              acc_load,
    input  logic [DATA_W-1:0] acc_load_data,
    output logic [PAGE_W-1:0] cur_q,
    output logic [PAGE_W-1:0] rd_q,
    output logic [PAGE_W-1:0] wr_q,
    output logic [DATA_W-1:0] acc_q
);
    logic sw_ok;
    assign sw_ok = wr_en && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             acc_q <= '0;
        else if (acc_load)                      acc_q <= acc_load_data;
        else if (sw_ok && (wr_sel == SEL_ACC))  acc_q <= wr_data;
    end

    generate
        if (PAGING_EN) begin : g_paged
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cur_q <= '0;
                    rd_q  <= '0;
                    wr_q  <= '0;
                end else if (sw_ok) begin
                    if (wr_sel == SEL_CUR)  cur_q <= wr_data[PAGE_W-1:0];
                    if (wr_sel == SEL_RDPG) rd_q  <= wr_data[PAGE_W-1:0];
                    if (wr_sel == SEL_WRPG) wr_q  <= wr_data[PAGE_W-1:0];
                end
            end

            // R8 / R4: page registers frozen while an instruction runs
            assert_pages_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
                busy |=> ($stable(cur_q) && $stable(rd_q) && $stable(wr_q)));
        end else begin : g_flat
            assign cur_q = '0;
            assign rd_q  = '0;
            assign wr_q  = '0;
        end
    endgenerate
endmodule

// File: rtl/ipi_move_unit.sv
`timescale 1ns/1ps
module ipi_move_unit
    import ipi_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter int         PAGE_W    = 3,
    parameter bit         PAGING_EN = 1'b1,
    parameter logic [7:0] OPC_LOAD  = 8'h3E,
    parameter logic [7:0] OPC_STORE = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] operand,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [PAGE_W-1:0] mem_page,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc,
    output logic [PAGE_W-1:0] cur_page,
    output logic [PAGE_W-1:0] rd_page,
    output logic [PAGE_W-1:0] wr_page,
    output logic              busy,
    output logic              done,
    output logic              illegal
);
    localparam logic [DATA_W-1:0] PTR_STEP = DATA_W'(1);

    ipi_state_e        state;
    logic              is_store;
    logic [DATA_W-1:0] ptr_addr;
    logic [DATA_W-1:0] ptr_q;
    logic              acc_load;

    ipi_seq_fsm #(
        .DATA_W   (DATA_W),
        .OPC_LOAD (OPC_LOAD),
        .OPC_STORE(OPC_STORE)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .opcode  (opcode),
        .operand (operand),
        .state   (state),
        .is_store(is_store),
        .ptr_addr(ptr_addr),
        .illegal (illegal)
    );

    ipi_ctx_regs #(
        .DATA_W   (DATA_W),
        .PAGE_W   (PAGE_W),
        .PAGING_EN(PAGING_EN)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy),
        .wr_en        (reg_we),
        .wr_sel       (reg_sel),
        .wr_data      (reg_wdata),
        .acc_load     (acc_load),
        .acc_load_data(mem_rdata),
        .cur_q        (cur_page),
        .rd_q         (rd_page),
        .wr_q         (wr_page),
        .acc_q        (acc)
    );

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ptr_q <= '0;
        else if (state == ST_DATA)  ptr_q <= mem_rdata;
    end

    always_comb begin
        mem_addr  = ptr_addr;
        mem_page  = cur_page;
        mem_wdata = acc;
        mem_we    = 1'b0;
        acc_load  = 1'b0;
        unique case (state)
            ST_PTR_RD: begin
                mem_addr = ptr_addr;
                mem_page = cur_page;
            end
            ST_DATA: begin
                mem_addr  = mem_rdata;
                mem_page  = is_store ? wr_page : rd_page;
                mem_wdata = acc;
                mem_we    = is_store;
            end
            ST_WB: begin
                mem_addr  = ptr_addr;
                mem_page  = cur_page;
                mem_wdata = ptr_q + PTR_STEP;
                mem_we    = 1'b1;
                acc_load  = !is_store;
            end
            default: begin
                mem_we = 1'b0;
            end
        endcase
    end

    // R7: an illegal opcode never comes with a RAM write
    assert_illegal_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_we);

    // R5: done is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: done is always preceded by the pointer write-back
    assert_done_after_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_we));
endmodule

// File: tb/test_ram.sv
`timescale 1ns/1ps
module test_ram #(
    parameter int PW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] page,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          bd_we,
    input  logic [PW-1:0] bd_page,
    input  logic [DW-1:0] bd_addr,
    input  logic [DW-1:0] bd_wdata
);
    logic [DW-1:0] mem [0:(1<<(PW+DW))-1];

    always @(posedge clk) begin
        if (bd_we)   mem[{bd_page, bd_addr}] <= bd_wdata;
        else if (we) mem[{page, addr}]       <= wdata;
        rdata <= mem[{page, addr}];
    end
endmodule

// File: tb/test_ipi_move_unit.sv
`timescale 1ns/1ps
module test_ipi_move_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, start_f = 1'b0;
    logic [7:0] opcode = 8'h00, operand = 8'h00;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic       bd_we = 1'b0;
    logic [2:0] bd_page = 3'd0;
    logic [7:0] bd_addr = 8'h00, bd_wdata = 8'h00;

    logic [7:0] mem_addr, mem_wdata, mem_rdata, acc;
    logic [2:0] mem_page, cur_page, rd_page, wr_page;
    logic       mem_we, busy, done, illegal;

    logic [7:0] mem_addr_f, mem_wdata_f, mem_rdata_f, acc_f;
    logic [2:0] mem_page_f, cur_page_f, rd_page_f, wr_page_f;
    logic       mem_we_f, busy_f, done_f, illegal_f;

    int checks = 0, errors = 0;
    int we_cnt = 0, done_cnt = 0, pg_bad = 0;

    always #5 clk = ~clk;

    ipi_move_unit i_ipi_move_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_addr(mem_addr), .mem_page(mem_page), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .acc(acc), .cur_page(cur_page), .rd_page(rd_page),
        .wr_page(wr_page), .busy(busy), .done(done), .illegal(illegal));

    ipi_move_unit #(.PAGING_EN(1'b0)) i_ipi_move_unit_flat (
        .clk(clk), .rst_n(rst_n), .start(start_f), .opcode(opcode), .operand(operand),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_addr(mem_addr_f), .mem_page(mem_page_f), .mem_wdata(mem_wdata_f), .mem_we(mem_we_f),
        .mem_rdata(mem_rdata_f), .acc(acc_f), .cur_page(cur_page_f), .rd_page(rd_page_f),
        .wr_page(wr_page_f), .busy(busy_f), .done(done_f), .illegal(illegal_f));

    test_ram i_ram (.clk(clk), .we(mem_we), .page(mem_page), .addr(mem_addr), .wdata(mem_wdata),
        .rdata(mem_rdata), .bd_we(bd_we), .bd_page(bd_page), .bd_addr(bd_addr), .bd_wdata(bd_wdata));
    test_ram i_ram_f (.clk(clk), .we(mem_we_f), .page(mem_page_f), .addr(mem_addr_f), .wdata(mem_wdata_f),
        .rdata(mem_rdata_f), .bd_we(bd_we), .bd_page(bd_page), .bd_addr(bd_addr), .bd_wdata(bd_wdata));

    always @(negedge clk) begin
        if (mem_we) we_cnt++;
        if (done) done_cnt++;
        if (busy_f && mem_page_f != 3'd0) pg_bad++;
    end

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] opd;
        logic [2:0] cur;
        logic [2:0] rdp;
        logic [2:0] wrp;
        logic [7:0] acc0;
        logic [7:0] ptr;
        logic [7:0] dat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{8'h3E, 8'h10, 3'd1, 3'd2, 3'd3, 8'h00, 8'h40, 8'hA5},
        '{8'h3F, 8'h11, 3'd1, 3'd2, 3'd3, 8'h5C, 8'h41, 8'h12},
        '{8'h3E, 8'h20, 3'd0, 3'd0, 3'd0, 8'h11, 8'hFF, 8'h77},
        '{8'h3F, 8'h21, 3'd4, 3'd5, 3'd6, 8'hC3, 8'hFF, 8'h34},
        '{8'h3E, 8'h30, 3'd7, 3'd7, 3'd1, 8'h00, 8'h00, 8'h3C},
        '{8'h3F, 8'h00, 3'd2, 3'd7, 3'd2, 8'h99, 8'h80, 8'h56}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bd_write(logic [2:0] pg, logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bd_we = 1'b1; bd_page = pg; bd_addr = a; bd_wdata = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic reg_write(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic run(logic [7:0] op, logic [7:0] opd, output int lat);
        @(negedge clk);
        opcode = op; operand = opd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        int lat, w0, d0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 acc", acc, 0);
        chk("R10 cur_page", cur_page, 0);
        chk("R10 rd_page", rd_page, 0);
        chk("R10 wr_page", wr_page, 0);
        chk("R10 busy/done/illegal/we", {busy, done, illegal, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: register port encodings
        reg_write(2'd0, 8'h05); chk("R8 sel0 cur", cur_page, 5);
        reg_write(2'd1, 8'h06); chk("R8 sel1 rd", rd_page, 6);
        reg_write(2'd2, 8'h03); chk("R8 sel2 wr", wr_page, 3);
        reg_write(2'd3, 8'hB7); chk("R8 sel3 acc", acc, 8'hB7);

        // vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            reg_write(2'd0, {5'd0, v.cur});
            reg_write(2'd1, {5'd0, v.rdp});
            reg_write(2'd2, {5'd0, v.wrp});
            reg_write(2'd3, v.acc0);
            bd_write(v.cur, v.opd, v.ptr);
            bd_write(v.wrp, v.ptr, ~v.dat);
            bd_write(v.rdp, v.ptr, v.dat);
            w0 = we_cnt;
            run(v.op, v.opd, lat);
            chk($sformatf("R5 latency v%0d", i), lat, 4);
            chk($sformatf("R3 ptr writeback v%0d", i), i_ram.mem[{v.cur, v.opd}], 8'(v.ptr + 8'd1));
            chk($sformatf("R4 cur unchanged v%0d", i), cur_page, v.cur);
            chk($sformatf("R4 rd/wr unchanged v%0d", i), {rd_page, wr_page}, {v.rdp, v.wrp});
            if (v.op == 8'h3E) begin
                chk($sformatf("R1 load acc v%0d", i), acc, v.dat);
                chk($sformatf("R1 one write v%0d", i), we_cnt - w0, 1);
            end else begin
                chk($sformatf("R2 store dest v%0d", i), i_ram.mem[{v.wrp, v.ptr}], v.acc0);
                chk($sformatf("R2 acc kept v%0d", i), acc, v.acc0);
                chk($sformatf("R2 two writes v%0d", i), we_cnt - w0, 2);
                if (v.rdp != v.wrp)
                    chk($sformatf("R2 read page untouched v%0d", i), i_ram.mem[{v.rdp, v.ptr}], v.dat);
            end
            @(negedge clk);
            chk($sformatf("R5 done drops v%0d", i), {done, busy}, 0);
        end

        // R7: illegal opcode
        reg_write(2'd3, 8'h5A);
        w0 = we_cnt; d0 = done_cnt;
        @(negedge clk);
        opcode = 8'h40; operand = 8'h10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 illegal pulse", {illegal, busy}, 2'b10);
        @(negedge clk);
        chk("R7 illegal clears", illegal, 0);
        repeat (5) @(negedge clk);
        chk("R7 no write/no done", {we_cnt - w0, done_cnt - d0}, 0);
        chk("R7 acc kept", acc, 8'h5A);

        // R6 and R8: start and register writes while busy
        reg_write(2'd0, 8'h01);
        reg_write(2'd2, 8'h03);
        reg_write(2'd3, 8'h21);
        bd_write(3'd1, 8'h50, 8'h60);
        bd_write(3'd1, 8'h51, 8'h70);
        w0 = we_cnt; d0 = done_cnt;
        @(negedge clk);
        opcode = 8'h3F; operand = 8'h50; start = 1'b1;
        @(negedge clk);
        opcode = 8'h3E; operand = 8'h51;
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h06;
        @(negedge clk);
        reg_we = 1'b0;
        while (!done) @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk("R6 single done", done_cnt - d0, 1);
        chk("R6 two writes only", we_cnt - w0, 2);
        chk("R6 second pointer untouched", i_ram.mem[{3'd1, 8'h51}], 8'h70);
        chk("R6 store landed", i_ram.mem[{3'd3, 8'h60}], 8'h21);
        chk("R8 write ignored while busy", cur_page, 1);

        // R9: paging disabled instance
        bd_write(3'd0, 8'h05, 8'h90);
        bd_write(3'd0, 8'h90, 8'h4B);
        @(negedge clk);
        opcode = 8'h3E; operand = 8'h05; start_f = 1'b1;
        @(negedge clk);
        start_f = 1'b0;
        lat = 1;
        while (!done_f && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk("R9 flat latency", lat, 4);
        chk("R9 flat page always 0", pg_bad, 0);
        chk("R9 flat pages read 0", {cur_page_f, rd_page_f, wr_page_f}, 0);
        chk("R9 flat load", acc_f, 8'h4B);
        chk("R9 flat ptr writeback", i_ram_f.mem[{3'd0, 8'h05}], 8'h91);

        report();
    end
endmodule